// File: doc/BRIEF.md
# Event Readiness Watchdog

This block sits beside the event processor and decides, for each event, whether processing may begin. A start-load pulse opens a collection window. While the window is open the block latches the done flag of every enabled input module, counts the data words each module delivers and captures the synchronisation tag (bunch-crossing or buffer number) that each module reports with its done flag. The enable mask is captured at start-load, so modules left out of the event are ignored for the whole window.

The window closes in one of two ways. If every enabled module reports done, the block runs two consistency checks. The first requires the designated single-word module to have sent exactly one word. The second requires all enabled modules to report the same tag. If both checks pass, the block issues a one-cycle processing-start pulse. If either check fails, or if the cycle budget runs out first, the block raises a global error line that asks the recovery logic for an automatic halt-recover-run. A cause code and a module index record what went wrong. These stay fixed until the next start-load.

The cycle budget is a parameter. Its default is 600 µs at a 50 MHz clock, which is 30000 cycles.

Top module: `evt_ready_wd`

## Requirements
- R1: After reset, `proc_start`, `err_line` and `busy` are 0, `err_cause` is 0 (none) and `err_mod` is 0.
- R2: Suppose all enabled modules have reported done and both checks pass. Then `proc_start` is 1 for exactly one cycle, in the cycle after the clock edge that samples the last done flag. When the captured mask is all zero, this happens in the second cycle after start-load is sampled.
- R3: Done flags, word strobes and tags of modules whose enable bit was 0 at start-load have no effect on the result.
- R4: If the enabled modules are not all done within `TIMEOUT_CYC` cycles of start-load, `err_line` rises after the `TIMEOUT_CYC`-th edge. `err_cause` is then 1 (timeout) and `err_mod` is the lowest enabled module that has not reported done.
- R5: If the single-word module (index `SINGLE_IDX`) is enabled and delivered zero words, `err_cause` is 2 (word count) and `err_mod` is `SINGLE_IDX`.
- R6: If the single-word module is enabled and delivered two or more words, the error is reported as in R5.
- R7: If the enabled tags differ, `err_cause` is 3 (sync). The reference tag is the tag of the lowest enabled module, and `err_mod` is the lowest enabled module whose tag differs from it.
- R8: `err_line`, `err_cause` and `err_mod` hold their values until the next start-load, and `proc_start` is never 1 while `err_line` is 1.
- R9: A start-load, including one that arrives during an open window, clears the error, the done flags, the word counts and the cycle timer.
- R10: When both checks fail on the same event, the word-count cause (2) is reported rather than the sync cause.
- R11: `busy` is 1 from the cycle after start-load is sampled until the window closes, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_load | input | 1 | Opens or restarts the collection window; captures `en_mask` |
| en_mask | input | NUM_MOD | Modules that take part in the event |
| mod_done | input | NUM_MOD | Done flag of each module |
| word_vld | input | NUM_MOD | One strobe per data word delivered by each module |
| mod_tag | input | NUM_MOD*TAG_W | Sync tag of each module, module i at bits [i*TAG_W +: TAG_W], sampled with its done flag |
| proc_start | output | 1 | One-cycle pulse: processing may begin |
| err_line | output | 1 | Global error, halt-recover-run request |
| err_cause | output | 2 | 0 none, 1 timeout, 2 word count, 3 sync mismatch |
| err_mod | output | IDX_W | Module blamed for the error |
| busy | output | 1 | Collection window open |

## Verification
The assertions check, on every cycle, the properties that hold regardless of stimulus:
- the start pulse is one cycle wide and never coincides with the error line;
- the error record stays stable until start-load;
- a word-count error always blames the single-word module;
- an open window never outlasts the cycle budget.

Which cause and which module are reported for a given pattern of masks, word counts and tags can only be shown by the bench's scenarios. The same holds for the exact cycle of the start pulse and of the timeout, the restart in mid-window, and the indifference to disabled modules.

// File: rtl/erw_pkg.sv
package erw_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE    = 2'd0,
      CAUSE_TIMEOUT = 2'd1,
      CAUSE_WORDS   = 2'd2,
      CAUSE_SYNC    = 2'd3
   } cause_e;

   typedef enum logic {
      ST_IDLE    = 1'b0,
      ST_COLLECT = 1'b1
   } state_e;

endpackage

// File: rtl/erw_gather.sv
// Per-module capture of done flags, sync tags and word counts.
module erw_gather #(
   parameter int NUM_MOD = 8,
   parameter int TAG_W   = 8,
   parameter int CNT_W   = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     active,
   input  logic [NUM_MOD-1:0]       mask,
   input  logic [NUM_MOD-1:0]       mod_done,
   input  logic [NUM_MOD-1:0]       word_vld,
   input  logic [NUM_MOD*TAG_W-1:0] mod_tag,
   output logic [NUM_MOD-1:0]       done_nxt,
   output logic [NUM_MOD*TAG_W-1:0] tag_nxt,
   output logic [NUM_MOD*CNT_W-1:0] cnt_nxt
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   for (genvar i = 0; i < NUM_MOD; i++) begin : g_mod
      logic             done_q;
      logic [TAG_W-1:0] tag_q;
      logic [CNT_W-1:0] cnt_q;
      logic             take;

      assign take = active & mask[i];
      assign done_nxt[i] = done_q | (take & mod_done[i]);
      assign tag_nxt[i*TAG_W +: TAG_W] = done_q ? tag_q : mod_tag[i*TAG_W +: TAG_W];
      assign cnt_nxt[i*CNT_W +: CNT_W] =
         (take && word_vld[i] && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n || clear) begin
            done_q <= 1'b0;
            tag_q  <= '0;
            cnt_q  <= '0;
         end else if (active) begin
            done_q <= done_nxt[i];
            tag_q  <= tag_nxt[i*TAG_W +: TAG_W];
            cnt_q  <= cnt_nxt[i*CNT_W +: CNT_W];
         end
      end
   end

endmodule

// File: rtl/erw_timer.sv
// Window timer: expires on the LIMIT-th running cycle.
module erw_timer #(
   parameter int LIMIT = 30000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expired
);

   localparam int TW = $clog2(LIMIT + 1);

   logic [TW-1:0] cnt_q;

   assign expired = run && (cnt_q == TW'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || clear)
         cnt_q <= '0;
      else if (run && !expired)
         cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/erw_judge.sv
// Combinational completion test and consistency checks.
module erw_judge
   import erw_pkg::*;
#(
   parameter int NUM_MOD    = 8,
   parameter int TAG_W      = 8,
   parameter int CNT_W      = 4,
   parameter int SINGLE_IDX = 0,
   parameter bit SYNC_CHECK = 1'b1,
   parameter int IDX_W      = 3
) (
   input  logic [NUM_MOD-1:0]       mask,
   input  logic [NUM_MOD-1:0]       done_nxt,
   input  logic [NUM_MOD*TAG_W-1:0] tag_nxt,
   input  logic [NUM_MOD*CNT_W-1:0] cnt_nxt,
   output logic                     all_done,
   output logic                     fail,
   output cause_e                   fail_cause,
   output logic [IDX_W-1:0]         fail_mod,
   output logic [IDX_W-1:0]         miss_mod
);

   logic             word_bad;
   logic             sync_bad;
   logic [IDX_W-1:0] sync_mod;

   assign all_done = &(done_nxt | ~mask);
   assign word_bad = mask[SINGLE_IDX] &&
                     (cnt_nxt[SINGLE_IDX*CNT_W +: CNT_W] != CNT_W'(1));

   always_comb begin
      miss_mod = '0;
      for (int i = NUM_MOD - 1; i >= 0; i--) begin
         if (mask[i] && !done_nxt[i]) miss_mod = IDX_W'(i);
      end
   end

   if (SYNC_CHECK) begin : g_sync
      logic [TAG_W-1:0] ref_tag;
      always_comb begin
         ref_tag  = '0;
         sync_bad = 1'b0;
         sync_mod = '0;
         for (int i = NUM_MOD - 1; i >= 0; i--) begin
            if (mask[i]) ref_tag = tag_nxt[i*TAG_W +: TAG_W];
         end
         for (int i = NUM_MOD - 1; i >= 0; i--) begin
            if (mask[i] && tag_nxt[i*TAG_W +: TAG_W] != ref_tag) begin
               sync_bad = 1'b1;
               sync_mod = IDX_W'(i);
            end
         end
      end
   end else begin : g_nosync
      assign sync_bad = 1'b0;
      assign sync_mod = '0;
   end

   always_comb begin
      fail       = word_bad | sync_bad;
      fail_cause = CAUSE_NONE;
      fail_mod   = '0;
      if (word_bad) begin
         fail_cause = CAUSE_WORDS;
         fail_mod   = IDX_W'(SINGLE_IDX);
      end else if (sync_bad) begin
         fail_cause = CAUSE_SYNC;
         fail_mod   = sync_mod;
      end
   end

endmodule

// File: rtl/evt_ready_wd.sv
module evt_ready_wd
   import erw_pkg::*;
#(
   parameter int NUM_MOD     = 8,
   parameter int TAG_W       = 8,
   parameter int CNT_W       = 4,
   parameter int CLK_MHZ     = 50,
   parameter int TIMEOUT_US  = 600,
   parameter int TIMEOUT_CYC = CLK_MHZ * TIMEOUT_US,
   parameter int SINGLE_IDX  = 0,
   parameter bit SYNC_CHECK  = 1'b1,
   localparam int IDX_W      = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_load,
   input  logic [NUM_MOD-1:0]       en_mask,
   input  logic [NUM_MOD-1:0]       mod_done,
   input  logic [NUM_MOD-1:0]       word_vld,
   input  logic [NUM_MOD*TAG_W-1:0] mod_tag,
   output logic                     proc_start,
   output logic                     err_line,
   output logic [1:0]               err_cause,
   output logic [IDX_W-1:0]         err_mod,
   output logic                     busy
);

   initial begin
      assert (NUM_MOD >= 1) else $error("NUM_MOD must be at least 1");
      assert (TAG_W >= 1) else $error("TAG_W must be at least 1");
      assert (CNT_W >= 2) else $error("CNT_W must be at least 2");
      assert (TIMEOUT_CYC >= 2) else $error("TIMEOUT_CYC must be at least 2");
      assert (SINGLE_IDX >= 0 && SINGLE_IDX < NUM_MOD)
         else $error("SINGLE_IDX out of range");
   end

   state_e                   state_q;
   cause_e                   cause_q;
   logic [NUM_MOD-1:0]       mask_q;
   logic                     active;
   logic                     expired;
   logic [NUM_MOD-1:0]       done_nxt;
   logic [NUM_MOD*TAG_W-1:0] tag_nxt;
   logic [NUM_MOD*CNT_W-1:0] cnt_nxt;
   logic                     all_done;
   logic                     fail;
   cause_e                   fail_cause;
   logic [IDX_W-1:0]         fail_mod;
   logic [IDX_W-1:0]         miss_mod;

   assign active = (state_q == ST_COLLECT) && !start_load;

   erw_gather #(
      .NUM_MOD (NUM_MOD),
      .TAG_W   (TAG_W),
      .CNT_W   (CNT_W)
   ) u_gather (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (start_load),
      .active   (active),
      .mask     (mask_q),
      .mod_done (mod_done),
      .word_vld (word_vld),
      .mod_tag  (mod_tag),
      .done_nxt (done_nxt),
      .tag_nxt  (tag_nxt),
      .cnt_nxt  (cnt_nxt)
   );

   erw_timer #(
      .LIMIT (TIMEOUT_CYC)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start_load),
      .run     (active),
      .expired (expired)
   );

   erw_judge #(
      .NUM_MOD    (NUM_MOD),
      .TAG_W      (TAG_W),
      .CNT_W      (CNT_W),
      .SINGLE_IDX (SINGLE_IDX),
      .SYNC_CHECK (SYNC_CHECK),
      .IDX_W      (IDX_W)
   ) u_judge (
      .mask       (mask_q),
      .done_nxt   (done_nxt),
      .tag_nxt    (tag_nxt),
      .cnt_nxt    (cnt_nxt),
      .all_done   (all_done),
      .fail       (fail),
      .fail_cause (fail_cause),
      .fail_mod   (fail_mod),
      .miss_mod   (miss_mod)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cause_q    <= CAUSE_NONE;
         err_line   <= 1'b0;
         err_mod    <= '0;
         mask_q     <= '0;
         proc_start <= 1'b0;
      end else begin
         proc_start <= 1'b0;
         if (start_load) begin
            state_q  <= ST_COLLECT;
            cause_q  <= CAUSE_NONE;
            err_line <= 1'b0;
            err_mod  <= '0;
            mask_q   <= en_mask;
         end else if (active) begin
            if (all_done) begin
               state_q <= ST_IDLE;
               if (fail) begin
                  err_line <= 1'b1;
                  cause_q  <= fail_cause;
                  err_mod  <= fail_mod;
               end else begin
                  proc_start <= 1'b1;
               end
            end else if (expired) begin
               state_q  <= ST_IDLE;
               err_line <= 1'b1;
               cause_q  <= CAUSE_TIMEOUT;
               err_mod  <= miss_mod;
            end
         end
      end
   end

   assign err_cause = cause_q;
   assign busy      = (state_q == ST_COLLECT);

endmodule

// File: rtl/erw_chk.sv
module erw_chk #(
   parameter int IDX_W       = 3,
   parameter int TIMEOUT_CYC = 30000,
   parameter int SINGLE_IDX  = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_load,
   input logic             proc_start,
   input logic             err_line,
   input logic [1:0]       err_cause,
   input logic [IDX_W-1:0] err_mod,
   input logic             busy
);

   localparam int BW = $clog2(TIMEOUT_CYC + 2);

   logic [BW-1:0] busy_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || start_load || !busy)
         busy_cnt <= '0;
      else
         busy_cnt <= busy_cnt + 1'b1;
   end

   // R2: start pulse lasts one cycle
   a_r2_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      proc_start |=> !proc_start);

   // R2: start pulse only closes an open window
   a_r2_start_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      proc_start |-> ($past(busy) && !busy));

   // R8: no start pulse while error pending
   a_r8_no_start_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      proc_start |-> !err_line);

   // R8: error record is held until a start-load
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_line && !start_load) |=> (err_line && $stable(err_cause) && $stable(err_mod)));

   // R8: a raised error always carries a cause
   a_r8_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      err_line |-> (err_cause != 2'd0));

   // R5: word-count errors blame the single-word module
   a_r5_word_err_mod: assert property (@(posedge clk) disable iff (!rst_n)
      (err_line && err_cause == 2'd2) |-> (err_mod == IDX_W'(SINGLE_IDX)));

   // R4: window never outlasts the budget
   a_r4_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_cnt < BW'(TIMEOUT_CYC)));

   // R9: start-load clears a pending error
   a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start_load |=> (!err_line && busy));

endmodule

bind evt_ready_wd erw_chk #(
   .IDX_W       (IDX_W),
   .TIMEOUT_CYC (TIMEOUT_CYC),
   .SINGLE_IDX  (SINGLE_IDX)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_load (start_load),
   .proc_start (proc_start),
   .err_line   (err_line),
   .err_cause  (err_cause),
   .err_mod    (err_mod),
   .busy       (busy)
);

// File: tb/tb_evt_ready_wd.sv
`timescale 1ns/1ps
module tb_evt_ready_wd;

   localparam int NM   = 4;
   localparam int TW   = 8;
   localparam int TO   = 40;
   localparam int IDXW = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start_load = 1'b0;
   logic [NM-1:0]   en_mask = '0;
   logic [NM-1:0]   mod_done = '0;
   logic [NM-1:0]   word_vld = '0;
   logic [NM*TW-1:0] mod_tag = '0;
   logic            proc_start;
   logic            err_line;
   logic [1:0]      err_cause;
   logic [IDXW-1:0] err_mod;
   logic            busy;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   always #10 clk = ~clk;

   evt_ready_wd #(
      .NUM_MOD     (NM),
      .TAG_W       (TW),
      .CNT_W       (4),
      .TIMEOUT_CYC (TO),
      .SINGLE_IDX  (0)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_load (start_load),
      .en_mask    (en_mask),
      .mod_done   (mod_done),
      .word_vld   (word_vld),
      .mod_tag    (mod_tag),
      .proc_start (proc_start),
      .err_line   (err_line),
      .err_cause  (err_cause),
      .err_mod    (err_mod),
      .busy       (busy)
   );

   // vector: mask(4) words(4) tags m3..m0 (32) cause(2) module(2)
   localparam int VN = 10;
   localparam logic [43:0] VEC [VN] = '{
      {4'hF, 4'd1, 32'hAAAAAAAA, 2'd0, 2'd0},  // R2 all agree
      {4'hF, 4'd0, 32'hAAAAAAAA, 2'd2, 2'd0},  // R5 no word
      {4'hF, 4'd2, 32'hAAAAAAAA, 2'd2, 2'd0},  // R6 two words
      {4'hF, 4'd1, 32'hAAAA55AA, 2'd3, 2'd1},  // R7 m1 differs
      {4'hF, 4'd1, 32'h11AAAAAA, 2'd3, 2'd3},  // R7 m3 differs
      {4'hD, 4'd1, 32'hAAAA55AA, 2'd0, 2'd0},  // R3 disabled m1
      {4'hE, 4'd0, 32'h33333300, 2'd0, 2'd0},  // R3 disabled m0
      {4'hF, 4'd3, 32'hAAAA55AA, 2'd2, 2'd0},  // R10 word over sync
      {4'hC, 4'd5, 32'h07070102, 2'd0, 2'd0},  // R3 only m2,m3
      {4'hE, 4'd0, 32'h33443300, 2'd3, 2'd2}   // R7 ref is m1
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_start(input logic [NM-1:0] m);
      @(negedge clk);
      en_mask    = m;
      start_load = 1'b1;
      @(negedge clk);
      start_load = 1'b0;
   endtask

   task automatic send_words(input int n);
      for (int k = 0; k < n; k++) begin
         word_vld[0] = 1'b1;
         @(negedge clk);
         word_vld[0] = 1'b0;
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog actual=%0d expected=finish", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(proc_start == 0, "R1", "proc_start", proc_start, 0);
      chk(err_line == 0, "R1", "err_line", err_line, 0);
      chk(err_cause == 0, "R1", "err_cause", err_cause, 0);
      chk(busy == 0, "R1", "busy", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < VN; v++) begin
         logic [3:0]  m;
         logic [3:0]  nw;
         logic [1:0]  ec;
         logic [1:0]  em;
         m  = VEC[v][43:40];
         nw = VEC[v][39:36];
         ec = VEC[v][3:2];
         em = VEC[v][1:0];
         mod_tag = VEC[v][35:4];
         do_start(m);
         chk(busy == 1, "R11", "busy after start", busy, 1);
         // disabled modules also strobe words to prove they are ignored (R3)
         word_vld[3:1] = ~m[3:1];
         send_words(int'(nw));
         word_vld = '0;
         mod_done = 4'hF;
         @(negedge clk);
         if (ec == 2'd0) begin
            chk(proc_start == 1, "R2", $sformatf("vec%0d start", v), proc_start, 1);
            chk(err_line == 0, "R3", $sformatf("vec%0d err", v), err_line, 0);
         end else begin
            chk(err_line == 1, "R7", $sformatf("vec%0d err", v), err_line, 1);
            chk(err_cause == ec, "R5", $sformatf("vec%0d cause", v), err_cause, ec);
            chk(err_mod == em, "R6", $sformatf("vec%0d module", v), err_mod, em);
         end
         chk(busy == 0, "R11", "busy after close", busy, 0);
         @(negedge clk);
         chk(proc_start == 0, "R2", "pulse width", proc_start, 0);
         mod_done = '0;
      end

      // R4 timeout with m2, m3 missing
      mod_tag = 32'h01010101;
      do_start(4'hF);
      mod_done = 4'h3;
      repeat (TO - 1) @(negedge clk);
      chk(err_line == 0, "R4", "no error before budget", err_line, 0);
      chk(busy == 1, "R11", "busy before budget", busy, 1);
      @(negedge clk);
      chk(err_line == 1, "R4", "error at budget", err_line, 1);
      chk(err_cause == 2'd1, "R4", "timeout cause", err_cause, 1);
      chk(err_mod == 2'd2, "R4", "lowest missing", err_mod, 2);
      // R8 sticky, late done does nothing
      mod_done = 4'hF;
      repeat (5) @(negedge clk);
      chk(err_line == 1, "R8", "error held", err_line, 1);
      chk(err_cause == 2'd1, "R8", "cause held", err_cause, 1);
      chk(proc_start == 0, "R8", "no start", proc_start, 0);
      mod_done = '0;

      // R9 start clears error; mid-window restart clears word count
      do_start(4'h1);
      chk(err_line == 0, "R9", "error cleared", err_line, 0);
      send_words(1);
      do_start(4'h1);
      send_words(1);
      mod_done = 4'h1;
      @(negedge clk);
      chk(proc_start == 1, "R9", "count cleared on restart", proc_start, 1);
      mod_done = '0;

      // R2 empty mask
      @(negedge clk);
      en_mask = '0;
      start_load = 1'b1;
      @(negedge clk);
      start_load = 1'b0;
      chk(proc_start == 0, "R2", "empty mask first cycle", proc_start, 0);
      @(negedge clk);
      chk(proc_start == 1, "R2", "empty mask start", proc_start, 1);

      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule